// File: doc/BRIEF.md
# Flash Word Program Sequencer

This block drives a 16-bit-wide parallel flash device in order to fill it one word at a time. A command supplies a start word address, a length and a poll limit. For each target word the block takes one word from a ready/valid input stream. It drives three fixed unlock write cycles on the flash pins, then writes the data word to its address. It then reads the device repeatedly until programming has finished, and moves on to the next ascending address.

The same command port can request block erases instead. Each erase is a six-cycle write sequence that ends at a block base address. Successive bases step by the block size. Completion uses the same read-polling scheme: while the device is busy, one status bit flips on every read.

Write-enable pulse widths and the read access time are counted in clock cycles. Polling stops after a programmable number of reads. In that case the block raises an error flag and abandons the rest of the command.

Top module: `flash_word_prog`

## Requirements
- R1: After reset, the write-enable, output-enable and chip-enable pins are high, the data-drive enable is low, busy, done and err are low, cmd_ready is high and wd_ready is low.
- R2: When cmd_erase=0, each target word produces exactly four write cycles, in this order: (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x00A0), (target address, stream word). Bits 15:8 are zero in the three unlock cycles.
- R3: Every write-enable low phase lasts at least WE_LO clocks, and every high phase between pulses lasts at least WE_HI clocks. Address and data stay stable while write-enable is low, and chip-enable is low during it.
- R4: After the last write of an item, the block reads the flash at the item address. The item is complete only when two consecutive reads return identical words. No further write happens before that.
- R5: Program targets run from cmd_addr upward in steps of one word, cmd_count items in all. Exactly one stream word is consumed per target, in stream order. wd_ready is high only while the block waits for data with the flash pins idle, and it stays high across a stream stall.
- R6: When cmd_erase=1, each of cmd_count blocks produces six writes: (0x5555,0x00AA), (0x2AAA,0x0055), (0x5555,0x0080), (0x5555,0x00AA), (0x2AAA,0x0055), (block base,0x0030). The bases are cmd_addr + k*BLK_WORDS, and no stream word is consumed.
- R7: If cmd_timeout reads pass without two identical consecutive reads, the block sets err, does not pulse done, returns to idle with pins released, and drops the remaining items. err clears when the next command is accepted.
- R8: done is a single-cycle pulse in the cycle busy falls after the last item completes. A command with cmd_count=0 produces the pulse with no flash cycle.
- R9: Write-enable and output-enable are never low together, and the data-drive enable is low whenever output-enable is low.
- R10: While busy, cmd_ready is low and cmd_valid has no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_erase | input | 1 | 1 = block erase, 0 = word program |
| cmd_addr | input | AW | Start word address (block base for erase) |
| cmd_count | input | AW+1 | Number of words or blocks |
| cmd_timeout | input | TO_W | Poll read limit per item |
| wd_valid | input | 1 | Stream word valid |
| wd_ready | output | 1 | Block takes a stream word |
| wd_data | input | DW | Stream word |
| fl_addr | output | AW | Flash word address |
| fl_dq_out | output | DW | Data driven to flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | DW | Data read from flash |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completed pulse |
| err | output | 1 | Poll limit reached on the last command |

## Verification
Programming is tried with a device that stays busy for several reads. This separates a correct toggle check from one that stops after the first or second read. It runs at the top of the address space to show that addresses ascend across the range boundary. A stalled stream with an instantly ready device shows that no write cycle leaks out while data is missing and that a settled item needs exactly two reads. An erase run separates the six-cycle erase sequence and block-sized stepping from the program path. A device that never settles, a zero-length command and commands held during a run separate the error stop, the empty-command pulse and the ignoring of new commands.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    B_IDLE, B_SETUP, B_WLO, B_WHI, B_RD
  } bus_st_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_ISSUE, S_WAIT_W, S_RD_REQ, S_WAIT_R
  } seq_st_t;

  localparam logic [15:0] UNLK_ADDR_HI = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_LO = 16'h2AAA;
  localparam logic [7:0]  KEY_FIRST    = 8'hAA;
  localparam logic [7:0]  KEY_SECOND   = 8'h55;
  localparam logic [7:0]  OP_PROGRAM   = 8'hA0;
  localparam logic [7:0]  OP_ERASE_PRE = 8'h80;
  localparam logic [7:0]  OP_BLK_ERASE = 8'h30;

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int AW     = 21,
  parameter int DW     = 16,
  parameter int WE_LO  = 4,
  parameter int WE_HI  = 3,
  parameter int RD_CYC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          ack,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          fl_ce_n
);

  localparam int MAXC = (WE_LO > WE_HI) ? ((WE_LO > RD_CYC) ? WE_LO : RD_CYC)
                                        : ((WE_HI > RD_CYC) ? WE_HI : RD_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam int RW   = $clog2(WE_LO + 2);

  bus_st_t       st;
  logic [CW-1:0] cnt;
  logic          is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= B_IDLE;
      cnt       <= '0;
      is_rd     <= 1'b0;
      ack       <= 1'b0;
      rd_data   <= '0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_we_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      fl_ce_n   <= 1'b1;
    end else begin
      ack <= 1'b0;
      case (st)
        B_IDLE: begin
          if (req) begin
            fl_addr   <= req_addr;
            fl_dq_out <= req_rd ? '0 : req_data;
            fl_dq_oe  <= !req_rd;
            fl_ce_n   <= 1'b0;
            is_rd     <= req_rd;
            st        <= B_SETUP;
          end
        end
        B_SETUP: begin
          cnt <= '0;
          if (is_rd) begin
            fl_oe_n <= 1'b0;
            st      <= B_RD;
          end else begin
            fl_we_n <= 1'b0;
            st      <= B_WLO;
          end
        end
        B_WLO: begin
          if (cnt == CW'(WE_LO - 1)) begin
            fl_we_n <= 1'b1;
            cnt     <= '0;
            st      <= B_WHI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        B_WHI: begin
          if (cnt == CW'(WE_HI - 1)) begin
            ack      <= 1'b1;
            fl_ce_n  <= 1'b1;
            fl_dq_oe <= 1'b0;
            st       <= B_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        B_RD: begin
          if (cnt == CW'(RD_CYC - 1)) begin
            rd_data <= fl_dq_in;
            fl_oe_n <= 1'b1;
            fl_ce_n <= 1'b1;
            ack     <= 1'b1;
            st      <= B_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  // Checker state: length of the current write-enable low run
  logic [RW-1:0] lo_run;
  always_ff @(posedge clk) begin
    if (rst)                 lo_run <= '0;
    else if (fl_we_n)        lo_run <= '0;
    else if (lo_run != '1)   lo_run <= lo_run + 1'b1;
  end

  // R3
  we_low_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (lo_run >= RW'(WE_LO)));

  // R3
  we_pins_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  // R3
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> !fl_ce_n);

  // R9
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> fl_oe_n);

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe);

endmodule

// File: rtl/flash_toggle_cmp.sv
module flash_toggle_cmp #(
  parameter int DW   = 16,
  parameter int TO_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            sample,
  input  logic [DW-1:0]   rd_word,
  input  logic [TO_W-1:0] limit,
  output logic            settled,
  output logic            expired
);

  logic [DW-1:0]   prev;
  logic            have_prev;
  logic [TO_W-1:0] reads;

  always_comb begin
    settled = sample && have_prev && (prev == rd_word);
    expired = sample && !settled && (({1'b0, reads} + 1'b1) >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev      <= '0;
      have_prev <= 1'b0;
      reads     <= '0;
    end else if (sample) begin
      prev      <= rd_word;
      have_prev <= 1'b1;
      if (reads != '1) reads <= reads + 1'b1;
    end
  end

endmodule

// File: rtl/flash_word_prog.sv
module flash_word_prog
  import flash_seq_pkg::*;
#(
  parameter int AW        = 21,
  parameter int DW        = 16,
  parameter int TO_W      = 24,
  parameter int WE_LO     = 4,
  parameter int WE_HI     = 3,
  parameter int RD_CYC    = 8,
  parameter int BLK_WORDS = 16384
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_erase,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [AW:0]     cmd_count,
  input  logic [TO_W-1:0] cmd_timeout,
  input  logic            wd_valid,
  output logic            wd_ready,
  input  logic [DW-1:0]   wd_data,
  output logic [AW-1:0]   fl_addr,
  output logic [DW-1:0]   fl_dq_out,
  output logic            fl_dq_oe,
  input  logic [DW-1:0]   fl_dq_in,
  output logic            fl_we_n,
  output logic            fl_oe_n,
  output logic            fl_ce_n,
  output logic            busy,
  output logic            done,
  output logic            err
);

  localparam logic [2:0]    LAST_PROG  = 3'd3;
  localparam logic [2:0]    LAST_ERASE = 3'd5;
  localparam logic [AW-1:0] BLK_STEP   = AW'(BLK_WORDS);

  seq_st_t         st;
  logic [AW-1:0]   cur_addr;
  logic [AW:0]     left;
  logic            is_erase;
  logic [DW-1:0]   word;
  logic [2:0]      step;
  logic [TO_W-1:0] tmo;

  logic            bus_req, bus_rd, bus_ack;
  logic [AW-1:0]   bus_addr;
  logic [DW-1:0]   bus_data, bus_rdata;
  logic            poll_clear, poll_sample, settled, expired;
  logic [2:0]      last_step;

  assign cmd_ready = (st == S_IDLE);
  assign wd_ready  = (st == S_FETCH);
  assign busy      = (st != S_IDLE);
  assign last_step = is_erase ? LAST_ERASE : LAST_PROG;

  assign bus_req     = (st == S_ISSUE) || (st == S_RD_REQ);
  assign bus_rd      = (st == S_RD_REQ);
  assign poll_clear  = (st == S_WAIT_W) && bus_ack && (step == last_step);
  assign poll_sample = (st == S_WAIT_R) && bus_ack;

  // Address and data of the current bus cycle
  always_comb begin
    bus_addr = cur_addr;
    bus_data = '0;
    if (st == S_ISSUE) begin
      unique case (step)
        3'd0: begin bus_addr = AW'(UNLK_ADDR_HI); bus_data = DW'(KEY_FIRST);  end
        3'd1: begin bus_addr = AW'(UNLK_ADDR_LO); bus_data = DW'(KEY_SECOND); end
        3'd2: begin
          bus_addr = AW'(UNLK_ADDR_HI);
          bus_data = is_erase ? DW'(OP_ERASE_PRE) : DW'(OP_PROGRAM);
        end
        3'd3: begin
          if (is_erase) begin
            bus_addr = AW'(UNLK_ADDR_HI); bus_data = DW'(KEY_FIRST);
          end else begin
            bus_addr = cur_addr;          bus_data = word;
          end
        end
        3'd4: begin bus_addr = AW'(UNLK_ADDR_LO); bus_data = DW'(KEY_SECOND); end
        default: begin bus_addr = cur_addr; bus_data = DW'(OP_BLK_ERASE); end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      left     <= '0;
      is_erase <= 1'b0;
      word     <= '0;
      step     <= '0;
      tmo      <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            err      <= 1'b0;
            cur_addr <= cmd_addr;
            left     <= cmd_count;
            is_erase <= cmd_erase;
            tmo      <= cmd_timeout;
            step     <= '0;
            if (cmd_count == '0) done <= 1'b1;
            else if (cmd_erase)  st   <= S_ISSUE;
            else                 st   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (wd_valid) begin
            word <= wd_data;
            step <= '0;
            st   <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_WAIT_W;
        S_WAIT_W: begin
          if (bus_ack) begin
            if (step == last_step) begin
              st <= S_RD_REQ;
            end else begin
              step <= step + 1'b1;
              st   <= S_ISSUE;
            end
          end
        end
        S_RD_REQ: st <= S_WAIT_R;
        S_WAIT_R: begin
          if (bus_ack) begin
            if (settled) begin
              if (left == (AW+1)'(1)) begin
                done <= 1'b1;
                st   <= S_IDLE;
              end else begin
                left     <= left - 1'b1;
                cur_addr <= cur_addr + (is_erase ? BLK_STEP : AW'(1));
                step     <= '0;
                st       <= is_erase ? S_ISSUE : S_FETCH;
              end
            end else if (expired) begin
              err <= 1'b1;
              st  <= S_IDLE;
            end else begin
              st <= S_RD_REQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  flash_bus_cycle #(
    .AW(AW), .DW(DW), .WE_LO(WE_LO), .WE_HI(WE_HI), .RD_CYC(RD_CYC)
  ) u_bus (
    .clk(clk), .rst(rst),
    .req(bus_req), .req_rd(bus_rd), .req_addr(bus_addr), .req_data(bus_data),
    .ack(bus_ack), .rd_data(bus_rdata),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ce_n(fl_ce_n)
  );

  flash_toggle_cmp #(.DW(DW), .TO_W(TO_W)) u_poll (
    .clk(clk), .rst(rst), .clear(poll_clear), .sample(poll_sample),
    .rd_word(bus_rdata), .limit(tmo), .settled(settled), .expired(expired)
  );

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd_ready);

  // R7
  err_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !done);

  // R5
  fetch_pins_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wd_ready |-> (fl_we_n && fl_oe_n && fl_ce_n));

endmodule

// File: tb/sim_flash_word_prog.sv
module sim_flash_word_prog;

  localparam int AW = 21;
  localparam int DW = 16;
  localparam int TO_W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic            cmd_valid = 1'b0, cmd_erase = 1'b0;
  logic [AW-1:0]   cmd_addr = '0;
  logic [AW:0]     cmd_count = '0;
  logic [TO_W-1:0] cmd_timeout = '0;
  logic            wd_valid = 1'b0;
  logic [DW-1:0]   wd_data = '0;
  logic [DW-1:0]   fl_dq_in = '0;
  logic            cmd_ready, wd_ready, fl_dq_oe, fl_we_n, fl_oe_n, fl_ce_n;
  logic            busy, done, err;
  logic [AW-1:0]   fl_addr;
  logic [DW-1:0]   fl_dq_out;

  flash_word_prog u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .cmd_timeout(cmd_timeout), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .fl_ce_n(fl_ce_n), .busy(busy), .done(done), .err(err)
  );

  int checks = 0, errors = 0;

  // Flash model: logs writes, toggles bit 6 on reads while busy
  int          wr_n = 0, rd_n = 0, busy_cfg = 0, busy_left = 0;
  logic [31:0] a_log [0:63];
  logic [15:0] d_log [0:63];
  logic        tog = 1'b0;

  always @(posedge fl_we_n or negedge fl_oe_n) begin
    if (!rst) begin
      if (!fl_oe_n) begin
        if (busy_left > 0) begin
          tog = ~tog;
          busy_left = busy_left - 1;
        end
        rd_n = rd_n + 1;
        fl_dq_in = 16'h1234 | {9'd0, tog, 6'd0};
      end else begin
        if (wr_n < 64) begin
          a_log[wr_n] = 32'(fl_addr);
          d_log[wr_n] = fl_dq_out;
        end
        wr_n = wr_n + 1;
        busy_left = busy_cfg;
      end
    end
  end

  // Pulse width monitor and done counter
  int lo_c = 0, hi_c = 0, min_lo = 999, min_hi = 999, done_cnt = 0;
  bit seen_pulse = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (!fl_we_n) begin
        if (lo_c == 0 && seen_pulse && hi_c < min_hi) min_hi = hi_c;
        lo_c = lo_c + 1;
      end else begin
        if (lo_c != 0) begin
          if (lo_c < min_lo) min_lo = lo_c;
          seen_pulse = 1;
          hi_c = 0;
        end
        lo_c = 0;
        hi_c = hi_c + 1;
      end
    end
  end
  always @(negedge clk) if (done) done_cnt = done_cnt + 1;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(input bit er, input int addr, input int cnt, input int to);
    @(negedge clk);
    cmd_erase = er; cmd_addr = AW'(addr); cmd_count = (AW+1)'(cnt);
    cmd_timeout = TO_W'(to); cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic push_word(input logic [15:0] d, input int gap);
    repeat (gap) @(negedge clk);
    wd_valid = 1'b1; wd_data = d;
    while (!wd_ready) @(negedge clk);
    @(negedge clk);
    wd_valid = 1'b0;
  endtask

  task automatic wait_end(input int start_done);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done_cnt != start_done || err) break;
    end
  endtask

  task automatic chk_wr(input string req, input int idx, input int a, input int d);
    chk(req, $sformatf("write %0d addr", idx), longint'(a_log[idx]), longint'(a));
    chk(req, $sformatf("write %0d data", idx), longint'(d_log[idx]), longint'(d));
  endtask

  task automatic chk_prog(input int base, input int a, input int d);
    chk_wr("R2", base,     32'h5555, 16'h00AA);
    chk_wr("R2", base + 1, 32'h2AAA, 16'h0055);
    chk_wr("R2", base + 2, 32'h5555, 16'h00A0);
    chk_wr("R5", base + 3, a, d);
  endtask

  task automatic test_reset();
    chk("R1", "we_n", fl_we_n, 1);
    chk("R1", "oe_n", fl_oe_n, 1);
    chk("R1", "ce_n", fl_ce_n, 1);
    chk("R1", "dq_oe", fl_dq_oe, 0);
    chk("R1", "busy/done/err", {busy, done, err}, 0);
    chk("R1", "cmd_ready", cmd_ready, 1);
    chk("R1", "wd_ready", wd_ready, 0);
  endtask

  task automatic test_program();
    int w0 = wr_n, r0 = rd_n, d0 = done_cnt;
    busy_cfg = 3;
    fork
      send_cmd(0, 32'h1FFFFE, 2, 100);
      begin push_word(16'hBEEF, 0); push_word(16'h0F0F, 3); end
    join
    wait_end(d0);
    chk("R2", "write count", wr_n - w0, 8);
    chk_prog(w0, 32'h1FFFFE, 16'hBEEF);
    chk_prog(w0 + 4, 32'h1FFFFF, 16'h0F0F);
    chk("R4", "poll reads (busy 3)", rd_n - r0, 8);
    chk("R8", "done pulses", done_cnt - d0, 1);
    chk("R8", "busy after done", busy, 0);
    chk("R7", "err", err, 0);
    chk("R3", "min we low >= 4", min_lo >= 4, 1);
    chk("R3", "min we high >= 3", min_hi >= 3, 1);
  endtask

  task automatic test_stall();
    int w0 = wr_n, r0 = rd_n, d0 = done_cnt;
    busy_cfg = 0;
    fork
      send_cmd(0, 32'h000100, 2, 100);
      push_word(16'h1111, 0);
    join
    repeat (200) @(negedge clk);
    chk("R5", "writes during stall", wr_n - w0, 4);
    chk("R4", "reads for ready device", rd_n - r0, 2);
    chk("R5", "wd_ready held in stall", wd_ready, 1);
    chk("R5", "busy in stall", busy, 1);
    push_word(16'h2222, 0);
    wait_end(d0);
    chk_prog(w0, 32'h000100, 16'h1111);
    chk_prog(w0 + 4, 32'h000101, 16'h2222);
    chk("R8", "done after stall", done_cnt - d0, 1);
  endtask

  task automatic test_erase();
    int w0 = wr_n, r0 = rd_n, d0 = done_cnt;
    busy_cfg = 5;
    send_cmd(1, 32'h004000, 2, 100);
    wait_end(d0);
    chk("R6", "erase write count", wr_n - w0, 12);
    for (int k = 0; k < 2; k++) begin
      chk_wr("R6", w0 + 6*k,     32'h5555, 16'h00AA);
      chk_wr("R6", w0 + 6*k + 1, 32'h2AAA, 16'h0055);
      chk_wr("R6", w0 + 6*k + 2, 32'h5555, 16'h0080);
      chk_wr("R6", w0 + 6*k + 3, 32'h5555, 16'h00AA);
      chk_wr("R6", w0 + 6*k + 4, 32'h2AAA, 16'h0055);
      chk_wr("R6", w0 + 6*k + 5, 32'h004000 + k*16384, 16'h0030);
    end
    chk("R4", "erase poll reads", rd_n - r0, 12);
    chk("R6", "no stream word taken", wd_ready, 0);
    chk("R8", "erase done", done_cnt - d0, 1);
  endtask

  task automatic test_timeout();
    int w0 = wr_n, r0 = rd_n, d0 = done_cnt;
    busy_cfg = 1000;
    fork
      send_cmd(0, 32'h000300, 3, 5);
      push_word(16'hAAAA, 0);
    join
    wait_end(d0);
    repeat (30) @(negedge clk);
    chk("R7", "err set", err, 1);
    chk("R7", "reads until limit", rd_n - r0, 5);
    chk("R7", "writes (one item)", wr_n - w0, 4);
    chk("R7", "no done", done_cnt - d0, 0);
    chk("R7", "stopped", {busy, wd_ready}, 0);
    chk("R7", "pins released", {fl_we_n, fl_oe_n, fl_ce_n, fl_dq_oe}, 4'b1110);
  endtask

  task automatic test_zero();
    int w0 = wr_n, d0 = done_cnt;
    send_cmd(0, 32'h000500, 0, 5);
    repeat (5) @(negedge clk);
    chk("R8", "zero-length done", done_cnt - d0, 1);
    chk("R7", "err cleared on new command", err, 0);
    chk("R8", "zero-length no writes", wr_n - w0, 0);
  endtask

  task automatic test_busy_ignore();
    int w0 = wr_n, d0 = done_cnt, rdy_seen = 0;
    busy_cfg = 2;
    send_cmd(0, 32'h000200, 1, 100);
    @(negedge clk);
    cmd_erase = 1'b1; cmd_addr = AW'(32'h000777); cmd_count = (AW+1)'(9);
    cmd_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cmd_ready) rdy_seen++;
    end
    push_word(16'h5A5A, 0);
    while (busy) begin
      @(negedge clk);
      if (busy && cmd_ready) rdy_seen++;
    end
    cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10", "cmd_ready while busy", rdy_seen, 0);
    chk("R10", "writes of first command only", wr_n - w0, 4);
    chk_prog(w0, 32'h000200, 16'h5A5A);
    chk("R10", "one done", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_program();
    test_stall();
    test_erase();
    test_timeout();
    test_zero();
    test_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule